// File: doc/BRIEF.md
# Descriptor ring completion tracker

This block follows a DMA engine as it consumes descriptors from a circular ring and turns that progress into request completions. The engine reports its head index. The tracker keeps its own software head and walks it forward, one slot per clock, until the two agree. Each slot it passes counts as one retired descriptor. Software-side logic registers each outstanding request in a small in-order queue, giving the start slot, the end slot (one past its last descriptor), a descriptor count and a tag. When the walking head lands on the end slot of the oldest request, that request completes with OK status.

Two paths end requests early. A flush first retires whatever the engine has already consumed, giving normal completions. It then aborts every request still queued, oldest first. Last, it brings the removed counter level with the added counter and returns the head to slot 0. A request submitted while the engine is not running carries no descriptors. It and every request ahead of it complete as aborted, in order.

Top module: `desc_trk`

## Requirements
- R1: After reset, sw_head_o, removed_o and added_o are 0, progress_o, owned_o and cmp_valid_o are low, and sub_ready_o is high.
- R2: While running_i is high and no flush is in progress, sw_head_o moves by exactly one slot per clock toward hw_head_i and wraps from RING_SLOTS-1 to 0. It does not move while running_i is low.
- R3: removed_o rises by one for every retired descriptor and never decreases.
- R4: progress_o is high for the one cycle after each retired descriptor. free_o always equals RING_SLOTS-1-(added_o-removed_o).
- R5: When the head steps onto the end slot of the oldest queued request, cmp_valid_o pulses with cmp_abort_o = 0 (OK) and cmp_tag_o equal to that request's tag. Requests complete strictly in submission order.
- R6: A retired descriptor whose slot lies in the oldest request's [start, end) span raises owned_o alongside progress_o. Any other retired descriptor leaves owned_o low and produces no completion.
- R7: A request accepted while running_i is high adds its sub_ndesc_i to added_o.
- R8: A request accepted while running_i is low leaves added_o unchanged. Every queued request, and then this one, completes with cmp_abort_o = 1, oldest first, one per cycle.
- R9: A flush_i pulse first retires slots up to hw_head_i with normal completions. It then aborts every remaining request oldest first (cmp_abort_o = 1). Finally it sets removed_o equal to added_o and sw_head_o to 0.
- R10: sub_ready_o is low while QDEPTH requests are queued and while a flush or abort sequence runs. A submission offered then is not taken, so added_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| running_i | input | 1 | Engine is running |
| hw_head_i | input | IDX_W | Head slot reported by the engine |
| flush_i | input | 1 | One-cycle request to flush all outstanding work |
| sub_valid_i | input | 1 | Request submission offered |
| sub_ready_o | output | 1 | Submission accepted this cycle |
| sub_start_i | input | IDX_W | First slot owned by the request |
| sub_end_i | input | IDX_W | Slot one past the request's last descriptor |
| sub_ndesc_i | input | IDX_W+1 | Descriptors written for the request |
| sub_tag_i | input | TAG_W | Request identifier |
| sw_head_o | output | IDX_W | Software head slot |
| removed_o | output | CNT_W | Retired descriptor count |
| added_o | output | CNT_W | Added descriptor count |
| free_o | output | CNT_W | Free ring slots |
| progress_o | output | 1 | A descriptor retired in the previous cycle |
| owned_o | output | 1 | That descriptor belonged to the oldest request |
| cmp_valid_o | output | 1 | Completion pulse |
| cmp_abort_o | output | 1 | Completion status, 1 = aborted |
| cmp_tag_o | output | TAG_W | Tag of the completing request |

## Verification
The bench walks the head across the ring boundary and also asks for no movement. A wrong wrap would overshoot or loop forever, and either shows up as a wrong retired count. Requests are separated by unowned header slots. A design that completed on the start slot, or that counted unowned slots as owned, would give the wrong tag order or the wrong owned count. The flush case places the engine head past the first request's end. A design that aborted before draining would report that request as aborted rather than OK, or would leave removed_o behind added_o. A full queue and a submission made while the engine is stopped check back-pressure and the in-order abort path.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_ABORT = 2'd2
  } trk_state_e;

  // next slot on a ring of the given size
  function automatic int ring_next(input int idx, input int slots);
    return (idx + 1 == slots) ? 0 : idx + 1;
  endfunction

  // slot h inside [s, e) on a ring, with wrap
  function automatic logic in_span(input int h, input int s, input int e);
    if (s <= e) return (h >= s) && (h < e);
    return (h >= s) || (h < e);
  endfunction
endpackage

// File: rtl/trk_req_queue.sv
module trk_req_queue #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [IDX_W-1:0] in_start,
  input  logic [IDX_W-1:0] in_end,
  input  logic [TAG_W-1:0] in_tag,
  output logic [IDX_W-1:0] out_start,
  output logic [IDX_W-1:0] out_end,
  output logic [TAG_W-1:0] out_tag,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] start_mem [DEPTH];
  logic [IDX_W-1:0] end_mem   [DEPTH];
  logic [TAG_W-1:0] tag_mem   [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign out_start = start_mem[rd_ptr];
  assign out_end   = end_mem[rd_ptr];
  assign out_tag   = tag_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      start_mem[wr_ptr] <= in_start;
      end_mem[wr_ptr]   <= in_end;
      tag_mem[wr_ptr]   <= in_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/trk_step.sv
module trk_step
  import trk_pkg::*;
#(
  parameter int RING_SLOTS = 16,
  parameter int IDX_W      = 4
) (
  input  logic             enable,
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] hw_head,
  input  logic             q_empty,
  input  logic [IDX_W-1:0] q_start,
  input  logic [IDX_W-1:0] q_end,
  output logic             step,
  output logic [IDX_W-1:0] head_nxt,
  output logic             owned,
  output logic             end_hit
);
  always_comb begin
    step     = enable && (head != hw_head);
    head_nxt = IDX_W'(ring_next(int'(head), RING_SLOTS));
    owned    = step && !q_empty && in_span(int'(head), int'(q_start), int'(q_end));
    end_hit  = step && !q_empty && (head_nxt == q_end);
  end
endmodule

// File: rtl/desc_trk.sv
module desc_trk
  import trk_pkg::*;
#(
  parameter int RING_SLOTS = 16,
  parameter int QDEPTH     = 4,
  parameter int CNT_W      = 16,
  parameter int TAG_W      = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              running_i,
  input  logic [$clog2(RING_SLOTS)-1:0]     hw_head_i,
  input  logic                              flush_i,
  input  logic                              sub_valid_i,
  output logic                              sub_ready_o,
  input  logic [$clog2(RING_SLOTS)-1:0]     sub_start_i,
  input  logic [$clog2(RING_SLOTS)-1:0]     sub_end_i,
  input  logic [$clog2(RING_SLOTS):0]       sub_ndesc_i,
  input  logic [TAG_W-1:0]                  sub_tag_i,
  output logic [$clog2(RING_SLOTS)-1:0]     sw_head_o,
  output logic [CNT_W-1:0]                  removed_o,
  output logic [CNT_W-1:0]                  added_o,
  output logic [CNT_W-1:0]                  free_o,
  output logic                              progress_o,
  output logic                              owned_o,
  output logic                              cmp_valid_o,
  output logic                              cmp_abort_o,
  output logic [TAG_W-1:0]                  cmp_tag_o
);
  localparam int IDX_W = $clog2(RING_SLOTS);

  trk_state_e       state;
  logic             flush_mode;
  logic [IDX_W-1:0] head;

  // named internal events
  logic             q_empty, q_full;
  logic [IDX_W-1:0] q_start, q_end;
  logic [TAG_W-1:0] q_tag;
  logic             step_en, step, owned, end_hit;
  logic [IDX_W-1:0] head_nxt;
  logic             push, pop, abort_pop;

  assign step_en     = ((state == ST_RUN) && running_i) || (state == ST_DRAIN);
  assign sub_ready_o = (state == ST_RUN) && !flush_i && !q_full;
  assign push        = sub_valid_i && sub_ready_o;
  assign abort_pop   = (state == ST_ABORT) && !q_empty;
  assign pop         = end_hit || abort_pop;

  trk_step #(.RING_SLOTS(RING_SLOTS), .IDX_W(IDX_W)) step_i (
    .enable(step_en), .head(head), .hw_head(hw_head_i),
    .q_empty(q_empty), .q_start(q_start), .q_end(q_end),
    .step(step), .head_nxt(head_nxt), .owned(owned), .end_hit(end_hit)
  );

  // a request made while stopped owns no slots
  trk_req_queue #(.DEPTH(QDEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .in_start(running_i ? sub_start_i : '0),
    .in_end(running_i ? sub_end_i : '0),
    .in_tag(sub_tag_i),
    .out_start(q_start), .out_end(q_end), .out_tag(q_tag),
    .empty(q_empty), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      flush_mode  <= 1'b0;
      head        <= '0;
      removed_o   <= '0;
      added_o     <= '0;
      progress_o  <= 1'b0;
      owned_o     <= 1'b0;
      cmp_valid_o <= 1'b0;
      cmp_abort_o <= 1'b0;
      cmp_tag_o   <= '0;
    end else begin
      progress_o  <= 1'b0;
      owned_o     <= 1'b0;
      cmp_valid_o <= 1'b0;
      if (step) begin
        head       <= head_nxt;
        removed_o  <= removed_o + 1'b1;
        progress_o <= 1'b1;
        owned_o    <= owned;
      end
      if (end_hit) begin
        cmp_valid_o <= 1'b1;
        cmp_abort_o <= 1'b0;
        cmp_tag_o   <= q_tag;
      end
      unique case (state)
        ST_RUN: begin
          if (flush_i) begin
            state      <= ST_DRAIN;
            flush_mode <= 1'b1;
          end else if (push && !running_i) begin
            state      <= ST_ABORT;
            flush_mode <= 1'b0;
          end
          if (push && running_i) added_o <= added_o + CNT_W'(sub_ndesc_i);
        end
        ST_DRAIN: begin
          if (!step) state <= ST_ABORT;
        end
        ST_ABORT: begin
          if (abort_pop) begin
            cmp_valid_o <= 1'b1;
            cmp_abort_o <= 1'b1;
            cmp_tag_o   <= q_tag;
          end else begin
            state <= ST_RUN;
            if (flush_mode) begin
              removed_o <= added_o;
              head      <= '0;
            end
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign sw_head_o = head;
  assign free_o    = CNT_W'(RING_SLOTS - 1) - (added_o - removed_o);
endmodule

// File: rtl/desc_trk_chk.sv
module desc_trk_chk
  import trk_pkg::*;
#(
  parameter int RING_SLOTS = 16,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(RING_SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] sw_head,
  input logic [IDX_W-1:0] hw_head,
  input logic [CNT_W-1:0] removed,
  input logic [CNT_W-1:0] added,
  input logic             progress,
  input logic             cmp_valid,
  input logic             cmp_abort,
  input logic             sub_ready,
  input logic             q_full
);
  // R2: head moves by one slot with wrap, or is reset to slot 0 by a flush
  assert_head_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_head != $past(sw_head)) |->
      ((int'(sw_head) == ring_next(int'($past(sw_head)), RING_SLOTS)) || (sw_head == '0)));

  // R3: removed count only climbs by one or jumps up to the added count
  assert_removed_mono_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (removed != $past(removed)) |->
      ((removed == $past(removed) + 1'b1) || (removed == added)));

  // R4: a progress pulse follows a cycle in which the heads differed
  assert_progress_R4: assert property (@(posedge clk) disable iff (!rst_n)
    progress |-> ($past(sw_head) != $past(hw_head)));

  // R5: an OK completion only ever comes with a retired descriptor
  assert_ok_with_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_abort) |-> progress);

  // R10: no acceptance while the request queue is full
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !sub_ready);
endmodule

bind desc_trk desc_trk_chk #(.RING_SLOTS(RING_SLOTS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_head(sw_head_o), .hw_head(hw_head_i),
  .removed(removed_o), .added(added_o), .progress(progress_o),
  .cmp_valid(cmp_valid_o), .cmp_abort(cmp_abort_o),
  .sub_ready(sub_ready_o), .q_full(q_full)
);

// File: tb/desc_trk_tb_top.sv
`timescale 1ns/1ps
module desc_trk_tb_top;
  localparam int RING   = 16;
  localparam int QD     = 4;
  localparam int IW     = $clog2(RING);
  localparam int CW     = 16;
  localparam int TW     = 4;
  // {engine head, expected retired total, expected progress pulses in step}
  localparam int VEC [6][3] = '{'{5, 5, 5}, '{9, 9, 4}, '{15, 15, 6},
                                '{3, 19, 4}, '{3, 19, 0}, '{10, 26, 7}};

  logic clk = 0, rst_n = 0, running = 0, flush = 0, sub_valid = 0;
  logic [IW-1:0] hw_head = '0, sub_start = '0, sub_end = '0;
  logic [IW:0]   sub_ndesc = '0;
  logic [TW-1:0] sub_tag = '0;
  logic          sub_ready, progress, owned, cmp_valid, cmp_abort;
  logic [IW-1:0] sw_head;
  logic [CW-1:0] removed, added, free_cnt;
  logic [TW-1:0] cmp_tag;

  int total = 0, bad = 0;
  int prog_n = 0, own_n = 0, log_n = 0, mono_bad = 0;
  int last_rem = 0;
  int log_tag [16];
  int log_ab  [16];

  always #4 clk = ~clk;

  desc_trk #(.RING_SLOTS(RING), .QDEPTH(QD), .CNT_W(CW), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .running_i(running), .hw_head_i(hw_head),
    .flush_i(flush), .sub_valid_i(sub_valid), .sub_ready_o(sub_ready),
    .sub_start_i(sub_start), .sub_end_i(sub_end), .sub_ndesc_i(sub_ndesc),
    .sub_tag_i(sub_tag), .sw_head_o(sw_head), .removed_o(removed),
    .added_o(added), .free_o(free_cnt), .progress_o(progress), .owned_o(owned),
    .cmp_valid_o(cmp_valid), .cmp_abort_o(cmp_abort), .cmp_tag_o(cmp_tag)
  );

  always @(negedge clk) begin
    if (!rst_n) last_rem = 0;
    else begin
      if (progress) prog_n++;
      if (owned) own_n++;
      if (cmp_valid && log_n < 16) begin
        log_tag[log_n] = int'(cmp_tag);
        log_ab[log_n]  = int'(cmp_abort);
        log_n++;
      end
      if (int'(removed) < last_rem) mono_bad++;
      last_rem = int'(removed);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    prog_n = 0; own_n = 0; log_n = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; running = 0; flush = 0; sub_valid = 0; hw_head = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    clear_logs();
  endtask

  task automatic submit(input int s, input int e, input int n, input int tag, output bit acc);
    @(negedge clk);
    sub_valid = 1; sub_start = IW'(s); sub_end = IW'(e);
    sub_ndesc = (IW+1)'(n); sub_tag = TW'(tag);
    #1 acc = sub_ready;
    @(negedge clk);
    sub_valid = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic check_log(input int idx, input int tag, input int ab, input string req);
    check(log_tag[idx] == tag, req, log_tag[idx], tag);
    check(log_ab[idx] == ab, req, log_ab[idx], ab);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit acc;
    // R1 reset state
    repeat (2) @(negedge clk);
    check(sw_head == 0 && removed == 0 && added == 0, "R1", int'(removed), 0);
    check(!progress && !owned && !cmp_valid, "R1", int'(cmp_valid), 0);
    check(sub_ready == 1, "R1", int'(sub_ready), 1);
    do_reset();

    // R4 single step timing
    @(negedge clk); running = 1; hw_head = 1;
    @(negedge clk);
    check(progress == 1 && sw_head == 1, "R4", int'(sw_head), 1);
    @(negedge clk);
    check(progress == 0, "R4", int'(progress), 0);
    do_reset();

    // R2/R3/R4 table walk including wrap and no-move
    running = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      prog_n = 0;
      hw_head = IW'(VEC[i][0]);
      repeat (20) @(negedge clk);
      check(int'(sw_head) == VEC[i][0], "R2", int'(sw_head), VEC[i][0]);
      check(int'(removed) == VEC[i][1], "R3", int'(removed), VEC[i][1]);
      check(prog_n == VEC[i][2], "R4", prog_n, VEC[i][2]);
    end
    // R2 no movement while stopped
    running = 0; hw_head = 14;
    repeat (5) @(negedge clk);
    check(sw_head == 10, "R2", int'(sw_head), 10);
    do_reset();

    // R5/R6/R7 in-order OK completions with unowned header slots
    running = 1;
    submit(1, 3, 3, 1, acc);
    submit(4, 6, 3, 2, acc);
    check(added == 6, "R7", int'(added), 6);
    check(free_cnt == 9, "R4", int'(free_cnt), 9);
    hw_head = 6;
    repeat (12) @(negedge clk);
    check(log_n == 2, "R5", log_n, 2);
    check_log(0, 1, 0, "R5");
    check_log(1, 2, 0, "R5");
    check(own_n == 4, "R6", own_n, 4);
    check(removed == 6 && free_cnt == 15, "R4", int'(free_cnt), 15);

    // R8 submission while stopped aborts queue in order
    clear_logs();
    submit(6, 8, 2, 3, acc);
    running = 0;
    submit(0, 0, 5, 4, acc);
    repeat (8) @(negedge clk);
    check(log_n == 2, "R8", log_n, 2);
    check_log(0, 3, 1, "R8");
    check_log(1, 4, 1, "R8");
    check(added == 8, "R8", int'(added), 8);
    check(sw_head == 6 && removed == 6, "R8", int'(removed), 6);
    running = 1; hw_head = 8;
    repeat (6) @(negedge clk);
    check(removed == 8 && log_n == 2, "R6", int'(removed), 8);

    // R9 flush drains first, then aborts, then resyncs
    clear_logs();
    submit(9, 11, 3, 5, acc);
    submit(12, 14, 3, 6, acc);
    running = 0; hw_head = 12;
    pulse_flush();
    repeat (12) @(negedge clk);
    check(log_n == 2, "R9", log_n, 2);
    check_log(0, 5, 0, "R9");
    check_log(1, 6, 1, "R9");
    check(own_n == 2, "R6", own_n, 2);
    check(removed == 14 && added == 14, "R9", int'(removed), 14);
    check(sw_head == 0, "R9", int'(sw_head), 0);
    check(mono_bad == 0, "R3", mono_bad, 0);
    hw_head = 0;
    @(negedge clk); running = 1;

    // R10 full queue back-pressure and busy during flush
    clear_logs();
    for (int k = 0; k < QD; k++) submit(k + 1, k + 2, 1, 7 + k, acc);
    check(sub_ready == 0, "R10", int'(sub_ready), 0);
    submit(9, 10, 3, 15, acc);
    check(acc == 0 && added == 18, "R10", int'(added), 18);
    running = 0;
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    check(sub_ready == 0, "R10", int'(sub_ready), 0);
    repeat (10) @(negedge clk);
    check(log_n == 4, "R9", log_n, 4);
    for (int k = 0; k < 4; k++) check_log(k, 7 + k, 1, "R9");
    check(removed == 18 && sub_ready == 1, "R10", int'(removed), 18);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule